// File: doc/BRIEF.md
# ALU Operation Decoder with Jump-Register and Shift Selects

This combinational decoder sits between the main control of a 32-bit single-cycle processor and its ALU. It takes the 2-bit ALU mode from the main control, the 6-bit function field of the instruction, and the 5-bit shift-amount field (instruction bits 10..6). From these it produces a 4-bit ALU operation code, a select that routes the shifter result to the ALU output, a 5-bit shift amount, and a select that steers the next-PC multiplexer to the first register operand.

Mode 00 always requests addition and mode 01 always requests subtraction. In both cases the function field is ignored. Mode 10 decodes the function field. That covers the usual arithmetic and logic operations, plus two extra R-format codes: a register-indirect jump and a shift left by the instruction's shift field. Mode 11 asks for a fixed left shift by 16, which loads the upper half of a word from an immediate. The jump and the shift both use opcode 000000, so the main control needs no new signal for either one. Every output is a pure function of the present inputs, with no clock and no state.

Top module: `alu_ctl_decoder`

## Requirements
- R1: With mode 00, the operation is add (0010), whatever the function field. The shifter select is 0, the jump select is 0 and the shift amount is 0.
- R2: With mode 01, the operation is subtract (0110), whatever the function field. The shifter select is 0, the jump select is 0 and the shift amount is 0.
- R3: With mode 10, the function fields map to operations as follows: 100000 to add (0010), 100010 to subtract (0110), 100100 to and (0000), 100101 to or (0001), 101010 to set-less-than (0111). In each of these cases the shifter select is 0, the jump select is 0 and the shift amount is 0.
- R4: With mode 10 and function 001000, the jump select is 1. The operation is held at add (0010), the shifter select is 0 and the shift amount is 0.
- R5: With mode 10 and function 000000, the operation is 1000, the shifter select is 1 and the shift amount equals the shift-field input.
- R6: With mode 11, the operation is 1000, the shifter select is 1 and the shift amount is 16. Both the function field and the shift-field input are ignored.
- R7: With mode 10 and any function field not listed in R3, R4 or R5, the operation is add (0010) and the shifter select, jump select and shift amount are all 0.
- R8: The jump select is 1 only for mode 10 together with function 001000.
- R9: The shift-field input reaches the shift-amount output only for mode 10 with function 000000. For every other input it has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_mode_i | input | 2 | ALU mode from main control |
| funct_i | input | 6 | Instruction function field |
| shamt_i | input | 5 | Instruction shift field (bits 10..6) |
| alu_opc_o | output | 4 | ALU operation code |
| shift_sel_o | output | 1 | Selects the shifter result |
| shift_amt_o | output | 5 | Shift distance for the shifter |
| jump_reg_o | output | 1 | Steers next PC to register operand A |

## Verification
The hardest condition to reach from the ports is a leak: the shift field, or the two function codes next to each other (000000 and 001000), affecting an output in a mode where they must be ignored. A single directed value cannot show the absence of such a leak. To expose it, the bench sweeps all 64 function values under every mode with a nonzero shift field, and checks every output against a model built from the requirements. Separate tasks then hit the jump, shift and upper-load cases with several shift values, including the extremes 0 and 31.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;

    localparam int FUNCT_W = 6;
    localparam int OPC_W   = 4;
    localparam int MODE_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_ADD   = 2'b00,
        MODE_SUB   = 2'b01,
        MODE_FIELD = 2'b10,
        MODE_UPPER = 2'b11
    } alu_mode_e;

    typedef enum logic [2:0] {
        FC_ADD,
        FC_SUB,
        FC_AND,
        FC_OR,
        FC_SLT,
        FC_JREG,
        FC_SHL,
        FC_OTHER
    } funct_class_e;

    typedef enum logic [1:0] {
        AMT_ZERO,
        AMT_FIELD,
        AMT_CONST
    } amt_src_e;

    localparam logic [FUNCT_W-1:0] FN_ADD  = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB  = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND  = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR   = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT  = 6'b101010;
    localparam logic [FUNCT_W-1:0] FN_JREG = 6'b001000;
    localparam logic [FUNCT_W-1:0] FN_SHL  = 6'b000000;

    localparam logic [OPC_W-1:0] OPC_AND   = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_OR    = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_SUB   = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_SLT   = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_SHIFT = 4'b1000;

endpackage

// File: rtl/funct_classifier.sv
module funct_classifier
    import alu_ctl_pkg::*;
(
    input  logic [FUNCT_W-1:0] funct_i,
    output funct_class_e       class_o
);

    always_comb begin
        unique case (funct_i)
            FN_ADD:  class_o = FC_ADD;
            FN_SUB:  class_o = FC_SUB;
            FN_AND:  class_o = FC_AND;
            FN_OR:   class_o = FC_OR;
            FN_SLT:  class_o = FC_SLT;
            FN_JREG: class_o = FC_JREG;
            FN_SHL:  class_o = FC_SHL;
            default: class_o = FC_OTHER;
        endcase
    end

endmodule

// File: rtl/op_mapper.sv
module op_mapper
    import alu_ctl_pkg::*;
(
    input  alu_mode_e        mode_i,
    input  funct_class_e     class_i,
    output logic [OPC_W-1:0] opc_o,
    output logic             shift_sel_o,
    output logic             jump_reg_o,
    output amt_src_e         amt_src_o
);

    always_comb begin
        opc_o       = OPC_ADD;
        shift_sel_o = 1'b0;
        jump_reg_o  = 1'b0;
        amt_src_o   = AMT_ZERO;
        unique case (mode_i)
            MODE_ADD:   opc_o = OPC_ADD;
            MODE_SUB:   opc_o = OPC_SUB;
            MODE_UPPER: begin
                opc_o       = OPC_SHIFT;
                shift_sel_o = 1'b1;
                amt_src_o   = AMT_CONST;
            end
            MODE_FIELD: begin
                unique case (class_i)
                    FC_ADD:   opc_o = OPC_ADD;
                    FC_SUB:   opc_o = OPC_SUB;
                    FC_AND:   opc_o = OPC_AND;
                    FC_OR:    opc_o = OPC_OR;
                    FC_SLT:   opc_o = OPC_SLT;
                    FC_JREG:  jump_reg_o = 1'b1;
                    FC_SHL: begin
                        opc_o       = OPC_SHIFT;
                        shift_sel_o = 1'b1;
                        amt_src_o   = AMT_FIELD;
                    end
                    FC_OTHER: opc_o = OPC_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/shamt_select.sv
module shamt_select
    import alu_ctl_pkg::*;
#(
    parameter int SHAMT_W     = 5,
    parameter int UPPER_SHIFT = 16
) (
    input  amt_src_e           src_i,
    input  logic [SHAMT_W-1:0] field_i,
    output logic [SHAMT_W-1:0] amt_o
);

    localparam logic [SHAMT_W-1:0] UpperAmt = SHAMT_W'(UPPER_SHIFT);

    always_comb begin
        unique case (src_i)
            AMT_FIELD: amt_o = field_i;
            AMT_CONST: amt_o = UpperAmt;
            default:   amt_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_ctl_decoder.sv
module alu_ctl_decoder
    import alu_ctl_pkg::*;
#(
    parameter int SHAMT_W     = 5,
    parameter int UPPER_SHIFT = 16
) (
    input  logic [MODE_W-1:0]  alu_mode_i,
    input  logic [FUNCT_W-1:0] funct_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [OPC_W-1:0]   alu_opc_o,
    output logic               shift_sel_o,
    output logic [SHAMT_W-1:0] shift_amt_o,
    output logic               jump_reg_o
);

    funct_class_e fclass;
    amt_src_e     amt_src;

    funct_classifier u_class (
        .funct_i (funct_i),
        .class_o (fclass)
    );

    op_mapper u_map (
        .mode_i      (alu_mode_e'(alu_mode_i)),
        .class_i     (fclass),
        .opc_o       (alu_opc_o),
        .shift_sel_o (shift_sel_o),
        .jump_reg_o  (jump_reg_o),
        .amt_src_o   (amt_src)
    );

    shamt_select #(
        .SHAMT_W     (SHAMT_W),
        .UPPER_SHIFT (UPPER_SHIFT)
    ) u_amt (
        .src_i   (amt_src),
        .field_i (shamt_i),
        .amt_o   (shift_amt_o)
    );

endmodule

// File: rtl/alu_ctl_decoder_chk.sv
module alu_ctl_decoder_chk
    import alu_ctl_pkg::*;
#(
    parameter int SHAMT_W     = 5,
    parameter int UPPER_SHIFT = 16
) (
    input logic [MODE_W-1:0]  alu_mode_i,
    input logic [FUNCT_W-1:0] funct_i,
    input logic [SHAMT_W-1:0] shamt_i,
    input logic [OPC_W-1:0]   alu_opc_o,
    input logic               shift_sel_o,
    input logic [SHAMT_W-1:0] shift_amt_o,
    input logic               jump_reg_o
);

    always_comb begin
        AST_ADD_MODE: assert (alu_mode_i != 2'b00 || (alu_opc_o == OPC_ADD && !shift_sel_o && !jump_reg_o)); // R1
        AST_SUB_MODE: assert (alu_mode_i != 2'b01 || (alu_opc_o == OPC_SUB && !shift_sel_o && !jump_reg_o)); // R2
        AST_JREG_HOLD: assert (!jump_reg_o || (alu_opc_o == OPC_ADD && !shift_sel_o)); // R4
        AST_SHIFT_OP: assert (!shift_sel_o || alu_opc_o == OPC_SHIFT); // R5
        AST_UPPER_AMT: assert (alu_mode_i != 2'b11 || (shift_sel_o && shift_amt_o == SHAMT_W'(UPPER_SHIFT))); // R6
        AST_JREG_ONLY: assert (!jump_reg_o || (alu_mode_i == 2'b10 && funct_i == FN_JREG)); // R8
        AST_FIELD_PASS: assert (!(alu_mode_i == 2'b10 && funct_i == FN_SHL) || shift_amt_o == shamt_i); // R9
        AST_AMT_IDLE: assert (shift_sel_o || shift_amt_o == '0); // R7
    end

endmodule

bind alu_ctl_decoder alu_ctl_decoder_chk #(
    .SHAMT_W     (SHAMT_W),
    .UPPER_SHIFT (UPPER_SHIFT)
) i_chk (
    .alu_mode_i  (alu_mode_i),
    .funct_i     (funct_i),
    .shamt_i     (shamt_i),
    .alu_opc_o   (alu_opc_o),
    .shift_sel_o (shift_sel_o),
    .shift_amt_o (shift_amt_o),
    .jump_reg_o  (jump_reg_o)
);

// File: tb/test_alu_ctl_decoder.sv
`timescale 1ns/1ps
module test_alu_ctl_decoder;

    logic       clk = 1'b0;
    logic [1:0] mode;
    logic [5:0] funct;
    logic [4:0] shamt;
    logic [3:0] opc;
    logic       ssel;
    logic [4:0] samt;
    logic       jreg;
    int         errors = 0;
    int         checks = 0;
    bit         done   = 1'b0;

    always #2 clk = ~clk;

    alu_ctl_decoder i_alu_ctl_decoder (
        .alu_mode_i  (mode),
        .funct_i     (funct),
        .shamt_i     (shamt),
        .alu_opc_o   (opc),
        .shift_sel_o (ssel),
        .shift_amt_o (samt),
        .jump_reg_o  (jreg)
    );

    task automatic apply(input logic [1:0] m, input logic [5:0] f, input logic [4:0] s);
        @(negedge clk);
        mode  = m;
        funct = f;
        shamt = s;
        #1;
    endtask

    task automatic expect_all(input string req, input logic [3:0] e_opc, input logic e_sel,
                              input logic [4:0] e_amt, input logic e_jr);
        checks++;
        if (opc !== e_opc || ssel !== e_sel || samt !== e_amt || jreg !== e_jr) begin
            errors++;
            $display("FAIL %s mode=%b funct=%b shamt=%0d: got opc=%b sel=%b amt=%0d jr=%b, exp opc=%b sel=%b amt=%0d jr=%b",
                     req, mode, funct, shamt, opc, ssel, samt, jreg, e_opc, e_sel, e_amt, e_jr);
        end
    endtask

    task automatic t_initial();
        apply(2'b00, 6'b000000, 5'd0);
        expect_all("R1", 4'b0010, 1'b0, 5'd0, 1'b0);
    endtask

    task automatic t_fixed_modes();
        apply(2'b00, 6'b101010, 5'd9);
        expect_all("R1", 4'b0010, 1'b0, 5'd0, 1'b0);
        apply(2'b01, 6'b001000, 5'd31);
        expect_all("R2", 4'b0110, 1'b0, 5'd0, 1'b0);
        apply(2'b01, 6'b000000, 5'd3);
        expect_all("R2", 4'b0110, 1'b0, 5'd0, 1'b0);
    endtask

    task automatic t_alu_functs();
        apply(2'b10, 6'b100000, 5'd7);  expect_all("R3", 4'b0010, 1'b0, 5'd0, 1'b0);
        apply(2'b10, 6'b100010, 5'd7);  expect_all("R3", 4'b0110, 1'b0, 5'd0, 1'b0);
        apply(2'b10, 6'b100100, 5'd7);  expect_all("R3", 4'b0000, 1'b0, 5'd0, 1'b0);
        apply(2'b10, 6'b100101, 5'd7);  expect_all("R3", 4'b0001, 1'b0, 5'd0, 1'b0);
        apply(2'b10, 6'b101010, 5'd7);  expect_all("R3", 4'b0111, 1'b0, 5'd0, 1'b0);
    endtask

    task automatic t_jump_reg();
        apply(2'b10, 6'b001000, 5'd0);  expect_all("R4", 4'b0010, 1'b0, 5'd0, 1'b1);
        apply(2'b10, 6'b001000, 5'd21); expect_all("R4", 4'b0010, 1'b0, 5'd0, 1'b1);
    endtask

    task automatic t_shift_field();
        apply(2'b10, 6'b000000, 5'd0);  expect_all("R5", 4'b1000, 1'b1, 5'd0, 1'b0);
        apply(2'b10, 6'b000000, 5'd5);  expect_all("R5", 4'b1000, 1'b1, 5'd5, 1'b0);
        apply(2'b10, 6'b000000, 5'd31); expect_all("R5", 4'b1000, 1'b1, 5'd31, 1'b0);
    endtask

    task automatic t_upper();
        apply(2'b11, 6'b000000, 5'd3);  expect_all("R6", 4'b1000, 1'b1, 5'd16, 1'b0);
        apply(2'b11, 6'b001000, 5'd31); expect_all("R6", 4'b1000, 1'b1, 5'd16, 1'b0);
        apply(2'b11, 6'b100010, 5'd0);  expect_all("R6", 4'b1000, 1'b1, 5'd16, 1'b0);
    endtask

    task automatic t_undefined();
        apply(2'b10, 6'b111111, 5'd12); expect_all("R7", 4'b0010, 1'b0, 5'd0, 1'b0);
        apply(2'b10, 6'b000010, 5'd12); expect_all("R7", 4'b0010, 1'b0, 5'd0, 1'b0);
    endtask

    // R8 and R9: sweep every mode and function with a nonzero shift field
    task automatic t_sweep();
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 64; f++) begin
                logic [3:0] e_opc;
                logic       e_sel;
                logic [4:0] e_amt;
                logic       e_jr;
                apply(2'(m), 6'(f), 5'd19);
                e_opc = 4'b0010; e_sel = 1'b0; e_amt = 5'd0; e_jr = 1'b0;
                if (m == 1) e_opc = 4'b0110;
                else if (m == 3) begin e_opc = 4'b1000; e_sel = 1'b1; e_amt = 5'd16; end
                else if (m == 2) begin
                    case (6'(f))
                        6'b100010: e_opc = 4'b0110;
                        6'b100100: e_opc = 4'b0000;
                        6'b100101: e_opc = 4'b0001;
                        6'b101010: e_opc = 4'b0111;
                        6'b001000: e_jr  = 1'b1;
                        6'b000000: begin e_opc = 4'b1000; e_sel = 1'b1; e_amt = 5'd19; end
                        default: ;
                    endcase
                end
                expect_all("R8_R9 sweep", e_opc, e_sel, e_amt, e_jr);
            end
        end
    endtask

    initial begin
        mode = '0; funct = '0; shamt = '0;
        t_initial();
        t_fixed_modes();
        t_alu_functs();
        t_jump_reg();
        t_shift_field();
        t_upper();
        t_undefined();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule